// File: doc/BRIEF.md
# Spacer-Safe Three-Valued Full Adder

This block is a combinational full adder whose every signal carries one of three states: a spacer that means "no data yet", a valid low and a valid high. Each signal is a 2-bit symbol. The element is meant to sit between storage stages of a self-timed pipeline that uses the spacer as its handshake request. It must never emit a valid value that its inputs do not yet justify, so that a downstream stage that latches on the first valid symbol always latches the final answer.

Outputs follow early-decision rules. The carry is a majority function, so it goes valid as soon as two inputs agree, even with the third still at the spacer. The sum is an odd-parity function and can never be decided early, so it is held at the spacer until all three inputs are valid. Inside, the carry comes from a network of three-valued NAND gates and is then reused to form the sum through OR, AND and inverter gates, as in a binary complex-gate adder. A final hold stage forces the sum to the spacer until every input is valid.

Top module: `tern_full_adder`

## Requirements
- R1: Symbol encoding on every port: 2'b00 is the spacer, 2'b01 is valid low (bit value 0), 2'b10 is valid high (bit value 1).
- R2: When all three inputs are valid, co_o and sum_o are valid and equal the carry and sum of a binary full adder on the three bit values.
- R3: When exactly two inputs are valid and equal and the third is the spacer, co_o is valid and equals the value of the two.
- R4: co_o is the spacer whenever it is not decided: fewer than two inputs valid, or exactly two valid with different values.
- R5: sum_o is the spacer whenever at least one input is the spacer.
- R6: Neither output ever carries the code 2'b11.
- R7: When each input moves only between the spacer and a valid value (never directly from low to high or back), no output ever changes directly from low to high or from high to low between two samples.
- R8: An input carrying the code 2'b11 behaves exactly as the spacer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 2 | First addend symbol |
| b_i | input | 2 | Second addend symbol |
| ci_i | input | 2 | Carry-in symbol |
| sum_o | output | 2 | Sum symbol |
| co_o | output | 2 | Carry-out symbol |

## Verification
The bench walks all 64 input codes, including the illegal code on each input, so a design that decoded 2'b11 as data would show a valid output where the spacer belongs. The partly valid patterns are the main target: a carry network built with strict gates would hold the carry at the spacer when two inputs agree, and a sum built with plain Kleene logic but without the final hold would still pass, while one built with ordinary binary gates would leak a valid sum early. A protocol-following random walk, where inputs only move through the spacer, catches any output that jumps between low and high without passing through the spacer, which is what a network that latched stale partial results or inverted a spacer would do.

// File: rtl/tfa_pkg.sv
package tfa_pkg;
  localparam int unsigned SYM_W = 2;
  localparam int unsigned N_OPND = 3;

  typedef enum logic [SYM_W-1:0] {
    SYM_MID = 2'b00,
    SYM_LO  = 2'b01,
    SYM_HI  = 2'b10,
    SYM_BAD = 2'b11
  } sym_t;

  typedef enum logic [2:0] {
    OP_NAND,
    OP_NOR,
    OP_AND,
    OP_OR,
    OP_INV,
    OP_XOR
  } gate_op_e;

  function automatic logic sym_valid(sym_t s);
    return (s == SYM_LO) || (s == SYM_HI);
  endfunction
endpackage

// File: rtl/tern_gate.sv
module tern_gate
  import tfa_pkg::*;
#(
  parameter int unsigned N_IN = 2,
  parameter gate_op_e    OP   = OP_NAND
) (
  input  sym_t in_i [N_IN],
  output sym_t out_o
);
  localparam int unsigned CNT_W = $clog2(N_IN + 1);
  localparam logic [CNT_W-1:0] N_ALL = CNT_W'(N_IN);

  logic [CNT_W-1:0] n_lo, n_hi;
  logic             any_mid, par;

  always_comb begin
    n_lo = '0;
    n_hi = '0;
    par  = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (in_i[i] == SYM_LO) n_lo = n_lo + CNT_W'(1);
      if (in_i[i] == SYM_HI) begin
        n_hi = n_hi + CNT_W'(1);
        par  = ~par;
      end
    end
    any_mid = (n_lo + n_hi) != N_ALL;
  end

  // early-decision Kleene evaluation
  always_comb begin
    out_o = SYM_MID;
    unique case (OP)
      OP_NAND: if (n_lo != '0) out_o = SYM_HI; else if (n_hi == N_ALL) out_o = SYM_LO;
      OP_AND:  if (n_lo != '0) out_o = SYM_LO; else if (n_hi == N_ALL) out_o = SYM_HI;
      OP_NOR:  if (n_hi != '0) out_o = SYM_LO; else if (n_lo == N_ALL) out_o = SYM_HI;
      OP_OR:   if (n_hi != '0) out_o = SYM_HI; else if (n_lo == N_ALL) out_o = SYM_LO;
      OP_INV:  if (!any_mid) out_o = (n_hi != '0) ? SYM_LO : SYM_HI;
      OP_XOR:  if (!any_mid) out_o = par ? SYM_HI : SYM_LO;
      default: out_o = SYM_MID;
    endcase
  end

  always_comb begin
    AST_GATE_LEGAL: assert (out_o != SYM_BAD); // R6
    if ((OP == OP_XOR || OP == OP_INV) && any_mid)
      AST_GATE_STRICT_WAIT: assert (out_o == SYM_MID); // R5
  end
endmodule

// File: rtl/tern_hold.sv
module tern_hold
  import tfa_pkg::*;
#(
  parameter int unsigned N_CTL = 3
) (
  input  sym_t ctl_i [N_CTL],
  input  sym_t d_i,
  output sym_t q_o
);
  logic all_ok;

  always_comb begin
    all_ok = 1'b1;
    for (int i = 0; i < N_CTL; i++)
      if (!sym_valid(ctl_i[i])) all_ok = 1'b0;
    q_o = all_ok ? d_i : SYM_MID;
  end

  always_comb begin
    if (!all_ok) AST_HOLD_SPACER: assert (q_o == SYM_MID); // R5
  end
endmodule

// File: rtl/tern_carry_net.sv
module tern_carry_net
  import tfa_pkg::*;
(
  input  sym_t opnd_i [N_OPND],
  output sym_t co_o
);
  sym_t pair_n [N_OPND];

  for (genvar p = 0; p < N_OPND; p++) begin : g_pair
    sym_t pin [2];
    assign pin[0] = opnd_i[p];
    assign pin[1] = opnd_i[(p + 1) % N_OPND];
    tern_gate #(.N_IN(2), .OP(OP_NAND)) u_nand2 (
      .in_i (pin),
      .out_o(pair_n[p])
    );
  end

  tern_gate #(.N_IN(N_OPND), .OP(OP_NAND)) u_nand3 (
    .in_i (pair_n),
    .out_o(co_o)
  );
endmodule

// File: rtl/tern_sum_net.sv
module tern_sum_net
  import tfa_pkg::*;
(
  input  sym_t opnd_i [N_OPND],
  input  sym_t co_i,
  output sym_t sum_o
);
  sym_t any_hi, co_n, one_only, all_hi, raw;
  sym_t inv_in [1];
  sym_t and_in [2];
  sym_t or_in  [2];

  tern_gate #(.N_IN(N_OPND), .OP(OP_OR)) u_or3 (
    .in_i (opnd_i),
    .out_o(any_hi)
  );

  assign inv_in[0] = co_i;
  tern_gate #(.N_IN(1), .OP(OP_INV)) u_inv (
    .in_i (inv_in),
    .out_o(co_n)
  );

  assign and_in[0] = any_hi;
  assign and_in[1] = co_n;
  tern_gate #(.N_IN(2), .OP(OP_AND)) u_and2 (
    .in_i (and_in),
    .out_o(one_only)
  );

  tern_gate #(.N_IN(N_OPND), .OP(OP_AND)) u_and3 (
    .in_i (opnd_i),
    .out_o(all_hi)
  );

  assign or_in[0] = one_only;
  assign or_in[1] = all_hi;
  tern_gate #(.N_IN(2), .OP(OP_OR)) u_or2 (
    .in_i (or_in),
    .out_o(raw)
  );

  // parity is never decidable early: gate by input validity
  tern_hold #(.N_CTL(N_OPND)) u_hold (
    .ctl_i(opnd_i),
    .d_i  (raw),
    .q_o  (sum_o)
  );
endmodule

// File: rtl/tern_full_adder.sv
module tern_full_adder
  import tfa_pkg::*;
(
  input  logic [1:0] a_i,
  input  logic [1:0] b_i,
  input  logic [1:0] ci_i,
  output logic [1:0] sum_o,
  output logic [1:0] co_o
);
  logic [SYM_W-1:0] raw_in [N_OPND];
  sym_t opnd [N_OPND];
  sym_t co_s, sum_s;

  assign raw_in[0] = a_i;
  assign raw_in[1] = b_i;
  assign raw_in[2] = ci_i;

  // illegal code folds to spacer
  for (genvar i = 0; i < N_OPND; i++) begin : g_clean
    assign opnd[i] = (raw_in[i] == SYM_BAD) ? SYM_MID : sym_t'(raw_in[i]);
  end

  tern_carry_net u_carry (
    .opnd_i(opnd),
    .co_o  (co_s)
  );

  tern_sum_net u_sum (
    .opnd_i(opnd),
    .co_i  (co_s),
    .sum_o (sum_s)
  );

  assign co_o  = co_s;
  assign sum_o = sum_s;

  int unsigned n_v, n_h;

  always_comb begin
    n_v = 0;
    n_h = 0;
    for (int i = 0; i < N_OPND; i++) begin
      if (raw_in[i] == 2'b01) n_v++;
      if (raw_in[i] == 2'b10) begin
        n_v++;
        n_h++;
      end
    end
  end

  always_comb begin
    AST_SUM_LEGAL: assert (sum_o != 2'b11); // R6
    AST_CO_LEGAL: assert (co_o != 2'b11); // R6
    if (n_v < 3) AST_SUM_WAIT: assert (sum_o == 2'b00); // R5
    if (n_v == 3) begin
      AST_CO_ADD: assert (co_o == ((n_h >= 2) ? 2'b10 : 2'b01)); // R2
      AST_SUM_ADD: assert (sum_o == ((n_h % 2 == 1) ? 2'b10 : 2'b01)); // R2
    end
    if (n_v == 2 && n_h == 2) AST_CO_EARLY_HI: assert (co_o == 2'b10); // R3
    if (n_v == 2 && n_h == 0) AST_CO_EARLY_LO: assert (co_o == 2'b01); // R3
    if (n_v < 2 || (n_v == 2 && n_h == 1)) AST_CO_UNDECIDED: assert (co_o == 2'b00); // R4
  end
endmodule

// File: tb/sim_tern_full_adder.sv
module sim_tern_full_adder;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] a, b, ci;
  logic [1:0] sum, co;
  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  tern_full_adder u0 (
    .a_i  (a),
    .b_i  (b),
    .ci_i (ci),
    .sum_o(sum),
    .co_o (co)
  );

  function automatic int val_of(logic [1:0] s);
    if (s == 2'b01) return 0;
    if (s == 2'b10) return 1;
    return -1;
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: a=%b b=%b ci=%b actual=%b expected=%b", req, a, b, ci, act, exp);
    end
  endtask

  // behavioural reference, compared at negedge
  task automatic compare_now();
    int v [3];
    int nv, nh, nl;
    logic [1:0] e_co, e_sum;
    string rq_co, rq_sum;
    bit bad_in;
    v[0] = val_of(a); v[1] = val_of(b); v[2] = val_of(ci);
    bad_in = (a == 2'b11) || (b == 2'b11) || (ci == 2'b11);
    nv = 0; nh = 0; nl = 0;
    foreach (v[k]) begin
      if (v[k] == 1) nh++;
      if (v[k] == 0) nl++;
      if (v[k] >= 0) nv++;
    end
    if (nh >= 2) e_co = 2'b10;
    else if (nl >= 2) e_co = 2'b01;
    else e_co = 2'b00;
    if (nv == 3) e_sum = (nh % 2 == 1) ? 2'b10 : 2'b01;
    else e_sum = 2'b00;
    if (nv == 3) begin rq_co = "R2 carry"; rq_sum = "R2 sum"; end
    else begin
      rq_sum = "R5 sum spacer";
      rq_co = (e_co != 2'b00) ? "R3 early carry" : "R4 carry undecided";
    end
    if (bad_in) begin rq_co = {"R8 ", rq_co}; rq_sum = {"R8 ", rq_sum}; end
    check(rq_co, co, e_co);
    check(rq_sum, sum, e_sum);
    n_cmp++;
    if (co == 2'b11 || sum == 2'b11) begin
      n_bad++;
      $display("FAIL R6: illegal output actual co=%b sum=%b expected not 11", co, sum);
    end
  endtask

  initial begin
    a = 2'b00; b = 2'b00; ci = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset spacer co", co, 2'b00);
    check("R1 reset spacer sum", sum, 2'b00);
    rst_ni = 1'b1;

    // all 64 codes, including illegal 11
    for (int i = 0; i < 64; i++) begin
      @(posedge clk);
      a = 2'(i); b = 2'(i >> 2); ci = 2'(i >> 4);
      @(negedge clk);
      compare_now();
    end

    // protocol walk: inputs move only through the spacer
    begin
      logic [15:0] lf = 16'hACE1;
      logic [1:0] p_co = 2'b00, p_sum = 2'b00;
      a = 2'b00; b = 2'b00; ci = 2'b00;
      for (int t = 0; t < 3000; t++) begin
        @(posedge clk);
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if (lf[0]) a  = (a  != 2'b00) ? 2'b00 : (lf[3] ? 2'b10 : 2'b01);
        if (lf[1]) b  = (b  != 2'b00) ? 2'b00 : (lf[4] ? 2'b10 : 2'b01);
        if (lf[2]) ci = (ci != 2'b00) ? 2'b00 : (lf[5] ? 2'b10 : 2'b01);
        @(negedge clk);
        compare_now();
        n_cmp++;
        if ((p_co == 2'b01 && co == 2'b10) || (p_co == 2'b10 && co == 2'b01) ||
            (p_sum == 2'b01 && sum == 2'b10) || (p_sum == 2'b10 && sum == 2'b01)) begin
          n_bad++;
          $display("FAIL R7: direct flip actual co %b->%b sum %b->%b expected via 00",
                   p_co, co, p_sum, sum);
        end
        p_co = co; p_sum = sum;
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule